// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel

This block is a single bus-master DMA channel for one audio stream. Software places a ring of up to 32 buffer descriptors in memory, points the channel at the ring, sets a last-valid index and sets the run bit. The channel reads each descriptor over a one-outstanding memory read port. It then hands out the sample addresses of that buffer one per consumer handshake, and moves on to the next index. When the buffer at the last-valid index finishes, the channel halts.

Status causes are sticky and cleared by writing ones. They drive a single interrupt line through per-cause enables. If the consumer asks for a sample while none is available, the channel flags a FIFO error. It also marks, on two strobes, whether the filler should repeat the last sample or send silence. A flag in the most recently fetched descriptor chooses between the two. Software can extend a halted ring by writing a later last-valid index while run is still set, and the channel resumes.

Top module: `audio_ring_dma`

## Requirements
- R1: A descriptor at index i is read as two words, the buffer address at ring base + 8*i and then the length word at ring base + 8*i + 4. Length word bits [15:0] give the sample count, bit 31 requests a completion interrupt and bit 30 selects zero fill. The memory request and address stay stable until the response strobe.
- R2: One sample is transferred per cycle in which smp_valid and smp_ready are both high. The k-th sample of a buffer has address buffer + 2*k. The position register (address 4) holds the samples remaining, so remaining plus transferred always equals the length.
- R3: After a buffer completes, and it is not the last valid one, the current index (address 1) advances by one, wrapping from 31 to 0. The prefetched index (address 3) reads the index after the descriptor most recently fetched.
- R4: Completing the buffer at the last-valid index (address 2) sets status bit 2 and halts the channel. Status bit 0 reads 1 while halted, and no memory requests are made while halted.
- R5: Status bit 1 is set whenever the channel is active and the current index equals the last-valid index.
- R6: Status bit 3 is set when a buffer whose descriptor has bit 31 set completes.
- R7: A consumer request (smp_ready high with smp_valid low) while run is set and the channel is not halted sets status bit 4. In that cycle it also raises fill_repeat if the latest fetched descriptor had bit 30 clear, or fill_zero if bit 30 was set.
- R8: Status bits 1 to 4 are cleared by writing 1 to them at address 5. Writing 0 leaves them unchanged, bit 0 ignores writes, and a new cause in the same cycle wins over the clear.
- R9: irq is high exactly when (bit 2 and control bit 2), (bit 4 and control bit 3) or (bit 3 and control bit 4) holds. Status bits 0 and 1 never raise irq.
- R10: With control bit 0 (run) at 0, no sample is transferred, the position holds and no underrun is flagged.
- R11: Writing control (address 6) with bit 1 set clears the current index, prefetched index, position, all sticky status bits and run, and leaves the channel halted. Bit 1 reads back 0. The same state holds after rst_n.
- R12: While halted at the last-valid index with run set, writing a different last-valid index makes the channel advance to the next index and resume.
- R13: A descriptor with length 0 completes without transferring any sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 ring base, 1 current index, 2 last-valid index, 3 prefetched index, 4 position, 5 status, 6 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory read request, held until mem_rvalid |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| smp_ready | input | 1 | Consumer asks for a sample |
| smp_valid | output | 1 | A sample address is offered |
| smp_addr | output | 32 | Address of the offered sample |
| fill_repeat | output | 1 | Starved request: repeat the last sample |
| fill_zero | output | 1 | Starved request: send a zero sample |
| irq | output | 1 | Interrupt from the enabled status causes |

## Verification
A wrong index or position shows up at smp_addr on the very next handshake, because every sample address is derived from the fetched buffer base and the remaining count. The bench compares the full address stream with a list built from its own descriptor table. A missed or early halt shows within one descriptor time: extra or missing samples appear, memory requests continue, or status bit 0 stays low. A sticky bit that is lost or wrongly set is seen on the next register read and on irq in the same cycle, and the bench probes each enable separately.

// File: rtl/ardma_pkg.sv
package ardma_pkg;

  typedef enum logic [1:0] {
    SQ_HALT,
    SQ_FETCH_BUF,
    SQ_FETCH_LEN,
    SQ_XFER
  } seq_state_e;

  // register addresses
  localparam logic [2:0] RA_RING   = 3'd0;
  localparam logic [2:0] RA_CUR    = 3'd1;
  localparam logic [2:0] RA_LAST   = 3'd2;
  localparam logic [2:0] RA_PRE    = 3'd3;
  localparam logic [2:0] RA_REMAIN = 3'd4;
  localparam logic [2:0] RA_STATUS = 3'd5;
  localparam logic [2:0] RA_CTRL   = 3'd6;

  // control bits
  localparam int CT_RUN     = 0;
  localparam int CT_RRST    = 1;
  localparam int CT_LAST_IE = 2;
  localparam int CT_FIFO_IE = 3;
  localparam int CT_IOC_IE  = 4;

  // descriptor flag bits in the length word
  localparam int DF_IOC   = 31;
  localparam int DF_ZFILL = 30;

  // address of one word of descriptor idx
  function automatic logic [31:0] desc_word_addr(input logic [31:0] ring,
                                                 input logic [31:0] idx,
                                                 input logic        second);
    return ring + (idx << 3) + (second ? 32'd4 : 32'd0);
  endfunction

  // address of the next sample: buffer plus bytes already consumed
  function automatic logic [31:0] sample_addr(input logic [31:0] buf_base,
                                              input logic [31:0] len,
                                              input logic [31:0] remain);
    return buf_base + ((len - remain) << 1);
  endfunction

endpackage

// File: rtl/ardma_cfg.sv
module ardma_cfg
  import ardma_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      ring_base,
  output logic [IDX_W-1:0] last_idx,
  output logic             run,
  output logic             last_ie,
  output logic             fifo_ie,
  output logic             ioc_ie,
  output logic             regs_rst,
  output logic             st_wr,
  output logic [4:1]       st_wdata,
  output logic [31:0]      ctrl_rd
);

  logic wr_ctrl;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign regs_rst = wr_ctrl && reg_wdata[CT_RRST];
  assign st_wr    = reg_wr && (reg_addr == RA_STATUS);
  assign st_wdata = reg_wdata[4:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      last_idx  <= '0;
      run       <= 1'b0;
      last_ie   <= 1'b0;
      fifo_ie   <= 1'b0;
      ioc_ie    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_RING) ring_base <= reg_wdata;
      if (reg_wr && reg_addr == RA_LAST) last_idx <= reg_wdata[IDX_W-1:0];
      if (wr_ctrl) begin
        run     <= reg_wdata[CT_RUN] && !reg_wdata[CT_RRST];
        last_ie <= reg_wdata[CT_LAST_IE];
        fifo_ie <= reg_wdata[CT_FIFO_IE];
        ioc_ie  <= reg_wdata[CT_IOC_IE];
      end
    end
  end

  assign ctrl_rd = {27'd0, ioc_ie, fifo_ie, last_ie, 1'b0, run};

endmodule

// File: rtl/ardma_status.sv
module ardma_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regs_rst,
  input  logic       halted,
  input  logic       ev_atlast,
  input  logic       ev_lastdone,
  input  logic       ev_iocdone,
  input  logic       ev_fifoerr,
  input  logic       st_wr,
  input  logic [4:1] st_wdata,
  input  logic       last_ie,
  input  logic       fifo_ie,
  input  logic       ioc_ie,
  output logic [4:0] status,
  output logic       irq
);

  logic [4:1] sticky_q;
  logic [4:1] sticky_d;

  always_comb begin
    sticky_d = sticky_q;
    if (st_wr) sticky_d = sticky_d & ~st_wdata;
    sticky_d[1] = sticky_d[1] | ev_atlast;
    sticky_d[2] = sticky_d[2] | ev_lastdone;
    sticky_d[3] = sticky_d[3] | ev_iocdone;
    sticky_d[4] = sticky_d[4] | ev_fifoerr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || regs_rst) sticky_q <= '0;
    else                    sticky_q <= sticky_d;
  end

  assign status = {sticky_q, halted};
  assign irq    = (sticky_q[2] && last_ie) || (sticky_q[4] && fifo_ie) ||
                  (sticky_q[3] && ioc_ie);

  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sticky_q) & ~sticky_q) &
      ~($past(st_wr) ? $past(st_wdata) : 4'b0000)) == 4'b0000) || $past(regs_rst));

  // R6
  ioc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_iocdone && !regs_rst) |=> sticky_q[3]);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_ie && !fifo_ie && !ioc_ie) |-> !irq);

endmodule

// File: rtl/ardma_seq.sv
module ardma_seq
  import ardma_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             regs_rst,
  input  logic [31:0]      ring_base,
  input  logic [IDX_W-1:0] last_idx,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             smp_ready,
  output logic             smp_valid,
  output logic [31:0]      smp_addr,
  output logic             fill_repeat,
  output logic             fill_zero,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] pre_idx,
  output logic [LEN_W-1:0] remain,
  output logic             halted,
  output logic             ev_atlast,
  output logic             ev_lastdone,
  output logic             ev_iocdone,
  output logic             ev_fifoerr
);

  localparam int PAD_I = 32 - IDX_W;
  localparam int PAD_L = 32 - LEN_W;

  seq_state_e       state_q;
  logic [IDX_W-1:0] civ_q, piv_q;
  logic [LEN_W-1:0] pos_q, len_q;
  logic [31:0]      buf_q, maddr_q;
  logic             ioc_q, zf_q, parked_q, drain_q;

  logic [IDX_W-1:0] nxt_idx, start_idx;
  logic             in_fetch, buf_done, xfer, starve, start;

  assign nxt_idx   = civ_q + 1'b1;
  assign start_idx = parked_q ? nxt_idx : civ_q;
  assign in_fetch  = (state_q == SQ_FETCH_BUF) || (state_q == SQ_FETCH_LEN);
  assign halted    = (state_q == SQ_HALT);

  assign smp_valid = (state_q == SQ_XFER) && run && (pos_q != '0);
  assign xfer      = smp_valid && smp_ready;
  assign buf_done  = (state_q == SQ_XFER) && run && (pos_q == '0);
  assign starve    = run && smp_ready && !smp_valid && !halted;
  assign start     = halted && run && !drain_q && (!parked_q || civ_q != last_idx);

  assign ev_atlast   = !halted && (civ_q == last_idx);
  assign ev_lastdone = buf_done && (civ_q == last_idx);
  assign ev_iocdone  = buf_done && ioc_q;
  assign ev_fifoerr  = starve;
  assign fill_repeat = starve && !zf_q;
  assign fill_zero   = starve && zf_q;

  assign mem_req  = in_fetch || drain_q;
  assign mem_addr = maddr_q;
  assign smp_addr = sample_addr(buf_q, {{PAD_L{1'b0}}, len_q}, {{PAD_L{1'b0}}, pos_q});
  assign cur_idx  = civ_q;
  assign pre_idx  = piv_q;
  assign remain   = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_HALT;
      civ_q    <= '0;
      piv_q    <= '0;
      pos_q    <= '0;
      len_q    <= '0;
      buf_q    <= '0;
      maddr_q  <= '0;
      ioc_q    <= 1'b0;
      zf_q     <= 1'b0;
      parked_q <= 1'b0;
      drain_q  <= 1'b0;
    end else if (regs_rst) begin
      state_q  <= SQ_HALT;
      civ_q    <= '0;
      piv_q    <= '0;
      pos_q    <= '0;
      ioc_q    <= 1'b0;
      zf_q     <= 1'b0;
      parked_q <= 1'b0;
      drain_q  <= (in_fetch || drain_q) && !mem_rvalid;
    end else begin
      if (drain_q && mem_rvalid) drain_q <= 1'b0;
      unique case (state_q)
        SQ_HALT: begin
          if (start) begin
            civ_q    <= start_idx;
            parked_q <= 1'b0;
            maddr_q  <= desc_word_addr(ring_base, {{PAD_I{1'b0}}, start_idx}, 1'b0);
            state_q  <= SQ_FETCH_BUF;
          end
        end
        SQ_FETCH_BUF: begin
          if (mem_rvalid) begin
            buf_q   <= mem_rdata;
            maddr_q <= maddr_q + 32'd4;
            state_q <= SQ_FETCH_LEN;
          end
        end
        SQ_FETCH_LEN: begin
          if (mem_rvalid) begin
            len_q   <= mem_rdata[LEN_W-1:0];
            pos_q   <= mem_rdata[LEN_W-1:0];
            ioc_q   <= mem_rdata[DF_IOC];
            zf_q    <= mem_rdata[DF_ZFILL];
            piv_q   <= civ_q + 1'b1;
            state_q <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (xfer) begin
            pos_q <= pos_q - 1'b1;
          end else if (buf_done) begin
            if (civ_q == last_idx) begin
              parked_q <= 1'b1;
              state_q  <= SQ_HALT;
            end else begin
              civ_q   <= nxt_idx;
              maddr_q <= desc_word_addr(ring_base, {{PAD_I{1'b0}}, nxt_idx}, 1'b0);
              state_q <= SQ_FETCH_BUF;
            end
          end
        end
        default: state_q <= SQ_HALT;
      endcase
    end
  end

  // R1
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && !regs_rst) |=> (pos_q == $past(pos_q) - 1'b1));

  // R3
  civ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (civ_q != $past(civ_q)) |-> ((civ_q == $past(civ_q) + 1'b1) || $past(regs_rst)));

  // R4
  halt_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(halted) && !$past(regs_rst)) |-> (civ_q == $past(last_idx)));

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && state_q == SQ_XFER && !regs_rst) |=> $stable(pos_q));

endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
  import ardma_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        smp_ready,
  output logic        smp_valid,
  output logic [31:0] smp_addr,
  output logic        fill_repeat,
  output logic        fill_zero,
  output logic        irq
);

  localparam int PAD_I = 32 - IDX_W;
  localparam int PAD_L = 32 - LEN_W;

  logic [31:0]      ring_base, ctrl_rd;
  logic [IDX_W-1:0] last_idx, cur_idx, pre_idx;
  logic [LEN_W-1:0] remain;
  logic             run, last_ie, fifo_ie, ioc_ie, regs_rst, st_wr, halted;
  logic [4:1]       st_wdata;
  logic [4:0]       status;
  logic             ev_atlast, ev_lastdone, ev_iocdone, ev_fifoerr;

  ardma_cfg #(.IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ring_base(ring_base), .last_idx(last_idx),
    .run(run), .last_ie(last_ie), .fifo_ie(fifo_ie), .ioc_ie(ioc_ie),
    .regs_rst(regs_rst), .st_wr(st_wr), .st_wdata(st_wdata), .ctrl_rd(ctrl_rd)
  );

  ardma_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .regs_rst(regs_rst),
    .ring_base(ring_base), .last_idx(last_idx),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .smp_ready(smp_ready), .smp_valid(smp_valid),
    .smp_addr(smp_addr), .fill_repeat(fill_repeat), .fill_zero(fill_zero),
    .cur_idx(cur_idx), .pre_idx(pre_idx), .remain(remain), .halted(halted),
    .ev_atlast(ev_atlast), .ev_lastdone(ev_lastdone),
    .ev_iocdone(ev_iocdone), .ev_fifoerr(ev_fifoerr)
  );

  ardma_status u_status (
    .clk(clk), .rst_n(rst_n), .regs_rst(regs_rst), .halted(halted),
    .ev_atlast(ev_atlast), .ev_lastdone(ev_lastdone),
    .ev_iocdone(ev_iocdone), .ev_fifoerr(ev_fifoerr),
    .st_wr(st_wr), .st_wdata(st_wdata), .last_ie(last_ie),
    .fifo_ie(fifo_ie), .ioc_ie(ioc_ie), .status(status), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      RA_RING:   reg_rdata = ring_base;
      RA_CUR:    reg_rdata = {{PAD_I{1'b0}}, cur_idx};
      RA_LAST:   reg_rdata = {{PAD_I{1'b0}}, last_idx};
      RA_PRE:    reg_rdata = {{PAD_I{1'b0}}, pre_idx};
      RA_REMAIN: reg_rdata = {{PAD_L{1'b0}}, remain};
      RA_STATUS: reg_rdata = {27'd0, status};
      RA_CTRL:   reg_rdata = ctrl_rd;
      default:   reg_rdata = '0;
    endcase
  end

  // R7
  fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_repeat && fill_zero) && !((fill_repeat || fill_zero) && smp_valid));

  // R4
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0]) && !$past(mem_req)) |-> !mem_req);

endmodule

// File: tb/audio_ring_dma_bench.sv
module audio_ring_dma_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        smp_ready = 1'b0;
  logic        smp_valid, fill_repeat, fill_zero, irq;
  logic [31:0] smp_addr;

  audio_ring_dma u_audio_ring_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .smp_ready(smp_ready), .smp_valid(smp_valid), .smp_addr(smp_addr),
    .fill_repeat(fill_repeat), .fill_zero(fill_zero), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] ring_tb;
  logic [31:0] d_buf [32];
  logic [31:0] d_len [32];
  logic [31:0] obs_q [$];
  logic [31:0] exp_q [$];
  int checks = 0, fails = 0, rep_cnt = 0, zero_cnt = 0, ready_mode = 0;
  bit  done = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] off;
    off = a - ring_tb;
    if (off >= 32'd256) return 32'd0;
    return off[2] ? d_len[off[7:3]] : d_buf[off[7:3]];
  endfunction

  function automatic logic [31:0] make_len(input int n, input bit ioc, input bit zf);
    return {ioc, zf, 14'd0, 16'(n)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mem_rvalid <= 1'b0;
    else begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= mem_word(mem_addr);
    end
  end

  always @(posedge clk) if (rst_n) begin
    if (smp_valid && smp_ready) obs_q.push_back(smp_addr);
    if (fill_repeat) rep_cnt++;
    if (fill_zero) zero_cnt++;
  end

  always @(negedge clk)
    smp_ready = (ready_mode == 1) || (ready_mode == 2 && $urandom_range(1, 0) == 1);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_halt(input string tag);
    logic [31:0] s;
    int n;
    n = 0;
    repeat (4) @(negedge clk);
    do begin rd(3'd5, s); n++; end while (!s[0] && n < 20000);
    chk(tag, {31'd0, s[0]}, 32'd1);
  endtask

  task automatic add_exp(input int idx);
    for (int k = 0; k < int'(d_len[idx][15:0]); k++)
      exp_q.push_back(d_buf[idx] + 32'(k) * 32'd2);
  endtask

  task automatic cmp_samples(input string tag);
    int bad;
    bad = -1;
    checks++;
    if (obs_q.size() != exp_q.size()) begin
      fails++;
      $display("FAIL %s sample count actual=%0d expected=%0d", tag, obs_q.size(), exp_q.size());
    end else begin
      for (int i = 0; i < exp_q.size(); i++) if (bad < 0 && obs_q[i] !== exp_q[i]) bad = i;
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s sample %0d actual=%0h expected=%0h", tag, bad, obs_q[bad], exp_q[bad]);
      end
    end
    obs_q.delete(); exp_q.delete();
  endtask

  task automatic setup_ring(input logic [31:0] rb);
    ring_tb = rb;
    for (int i = 0; i < 32; i++) begin
      d_buf[i] = 32'h0010_0000 + 32'(i) * 32'h1000 + (rb & 32'hff0);
      d_len[i] = 32'd0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, p1, p2;
    int n, s1, s2;
    bit any_ioc;
    void'($urandom(32'd4242));
    setup_ring(32'h4000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R11 and R4
    rd(3'd5, v); chk("R11 reset status", v, 32'd1);
    rd(3'd1, v); chk("R11 reset cur idx", v, 32'd0);
    rd(3'd4, v); chk("R11 reset position", v, 32'd0);
    chk("R4 no request while halted", {31'd0, mem_req}, 32'd0);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);

    // random rings: R1 R2 R3 R4 R5 R6 R13
    for (int r = 0; r < 5; r++) begin
      wr(3'd6, 32'h2);
      setup_ring(32'h4000 + 32'(r) * 32'h400);
      n = $urandom_range(6, 1);
      any_ioc = 0;
      for (int i = 0; i < n; i++) begin
        d_len[i] = make_len((r == 0 && i == 0) ? 0 : $urandom_range(5, 0),
                            $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1);
        any_ioc |= d_len[i][31];
        add_exp(i);
      end
      wr(3'd0, ring_tb);
      wr(3'd2, 32'(n - 1));
      ready_mode = 2;
      wr(3'd6, 32'h1);
      wait_halt("R4 halted after ring");
      ready_mode = 0;
      cmp_samples("R1 R2 R13 sample stream");
      rd(3'd1, v); chk("R3 cur idx at last valid", v, 32'(n - 1));
      rd(3'd3, v); chk("R3 prefetched idx", v, 32'(n));
      rd(3'd4, v); chk("R2 position drained", v, 32'd0);
      rd(3'd5, v);
      chk("R4 last done bit", {31'd0, v[2]}, 32'd1);
      chk("R5 at-last bit", {31'd0, v[1]}, 32'd1);
      chk("R6 completion bit", {31'd0, v[3]}, {31'd0, any_ioc});
      chk("R4 quiet memory", {31'd0, mem_req}, 32'd0);
    end

    // underrun fill kinds, R7
    wr(3'd6, 32'h2);
    setup_ring(32'h5000);
    d_len[0] = make_len(2, 0, 1);
    d_len[1] = make_len(2, 0, 0);
    wr(3'd0, ring_tb); wr(3'd2, 32'd1);
    rep_cnt = 0; zero_cnt = 0; ready_mode = 1;
    wr(3'd6, 32'h1);
    wait_halt("R7 halted");
    ready_mode = 0;
    obs_q.delete();
    chk("R7 repeat fills seen", {31'd0, rep_cnt > 0}, 32'd1);
    chk("R7 zero fills seen", {31'd0, zero_cnt > 0}, 32'd1);
    rd(3'd5, v); chk("R7 fifo error status", v, 32'h17);

    // W1C and interrupt masking, R8 R9
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h9);
    @(negedge clk); chk("R9 fifo irq", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R8 zero write keeps status", v, 32'h17);
    wr(3'd5, 32'h10);
    rd(3'd5, v); chk("R8 clear bit 4", v, 32'h07);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h5);
    @(negedge clk); chk("R9 last-valid irq", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h01);
    rd(3'd5, v); chk("R8 bit 0 ignores write", v, 32'h07);
    wr(3'd6, 32'h1D);
    wr(3'd5, 32'h1C);
    rd(3'd5, v); chk("R8 clear 2..4 keeps bit 1", v, 32'h03);
    chk("R9 bits 0 and 1 raise no irq", {31'd0, irq}, 32'd0);

    // pause then register reset, R10 R11
    wr(3'd6, 32'h2);
    setup_ring(32'h6000);
    d_len[0] = make_len(40, 0, 0);
    wr(3'd0, ring_tb); wr(3'd2, 32'd0);
    wr(3'd6, 32'h1);
    n = 0;
    while (!smp_valid && n < 100) begin @(negedge clk); n++; end
    ready_mode = 1;
    repeat (5) @(negedge clk);
    wr(3'd6, 32'h0);
    rep_cnt = 0;
    rd(3'd4, p1); s1 = obs_q.size();
    repeat (10) @(negedge clk);
    rd(3'd4, p2); s2 = obs_q.size();
    chk("R10 position held", p2, p1);
    chk("R10 no transfers", 32'(s2), 32'(s1));
    chk("R2 remain plus sent", p1 + 32'(s1), 32'd40);
    chk("R10 no fills while paused", 32'(rep_cnt), 32'd0);
    rd(3'd5, v); chk("R10 no fifo error", {31'd0, v[4]}, 32'd0);
    ready_mode = 0;
    wr(3'd6, 32'h3);
    rd(3'd4, v); chk("R11 position cleared", v, 32'd0);
    rd(3'd5, v); chk("R11 status halted only", v, 32'd1);
    rd(3'd6, v); chk("R11 run cleared", v, 32'd0);
    rd(3'd3, v); chk("R11 prefetched cleared", v, 32'd0);
    obs_q.delete();

    // wrap and resume, R3 R12 R13
    setup_ring(32'h7000);
    d_len[0]  = make_len(3, 0, 0);
    d_len[1]  = make_len(2, 0, 0);
    d_len[31] = make_len(4, 0, 0);
    wr(3'd0, ring_tb); wr(3'd2, 32'd31);
    ready_mode = 2;
    wr(3'd6, 32'h1);
    wait_halt("R13 zero-length walk halts");
    add_exp(0); add_exp(1); add_exp(31);
    cmp_samples("R13 only non-empty buffers sent");
    rd(3'd1, v); chk("R3 index reached 31", v, 32'd31);
    wr(3'd2, 32'd1);
    wait_halt("R12 resumed ring halts");
    ready_mode = 0;
    add_exp(0); add_exp(1);
    cmp_samples("R12 R3 wrapped stream");
    rd(3'd1, v); chk("R12 cur idx after resume", v, 32'd1);
    rd(3'd3, v); chk("R3 prefetched after wrap", v, 32'd2);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule